// File: doc/BRIEF.md
# Floating-Point Issue Timing Scoreboard

This block sits in front of a floating-point execution pipeline and decides, in the same cycle a decoded instruction is offered, whether that instruction may start. Each request carries an operation class, a precision flag, a destination field, two source fields and a register count for block transfers. The block keeps one countdown per single-precision register, which says how many cycles remain before that register's pending result can be forwarded to a consumer. It also keeps countdowns for the iterative divide/square-root unit, for the double-precision multiplier, for block transfers that occupy the issue slot, and for the comparison flags.

A request that finds a source or destination still pending, a needed unit still occupied, or an issue slot held by a block transfer is stalled. A control-register transfer is stalled until every countdown has reached zero. The requester holds its request until `issue` is seen. Arithmetic, memory wait states and exceptions are handled elsewhere. Load timing assumes a cache hit.

Top module: `fp_issue_sb`

## Requirements
- R1: After reset every countdown is zero, so the first request issues in the cycle it is offered; `stall` is low whenever `req_valid` is low.
- R2: Class codes on `req_class`: 0 unary (abs/neg/convert/copy), 1 compare, 2 add/sub/int-conversion, 3 multiply/multiply-accumulate, 4 divide/sqrt, 5 load, 6 store, 7 block load, 8 block store, 9 core-to-FP move, 10 FP-to-core move, 11 flag transfer, 12 control write, 13 control read. Source A is read by codes 0,1,2,3,4,6,10, and source B by codes 1,2,3,4. Codes 14 and 15 touch nothing.
- R3: A consumer of a register written by an instruction of latency L may issue L-1 cycles after the producer, because of forwarding. The single-precision latencies are 4 for unary, load and core-to-FP; 8 for add and multiply; and 19 for divide.
- R4: With `req_dbl` set, a 5-bit field names double register d = field[3:0], and d is the pair of single registers 2d and 2d+1. Both halves are checked and both are written. Double multiply has latency 9 and double divide has latency 33.
- R5: Multiply accepts a new multiply 1 cycle after a single-precision multiply and 2 cycles after a double-precision one. The multiplier never stalls other classes.
- R6: Divide/sqrt accepts the next divide/sqrt 15 cycles (single) or 29 cycles (double) after issue. Other classes keep issuing meanwhile.
- R7: A block load or store with count N (0 treated as 1) covers single registers base..base+N-1 modulo 32. The base is the destination field for a load and source A for a store. It blocks all issue for X-1 cycles, where X = ceil(N/2). A block load gives its registers latency X+3.
- R8: Store, block store, FP-to-core and control transfers write no FP register, and their destination fields have no effect.
- R9: A compare writes no FP register but makes the flags pending with latency 4. A flag transfer waits for them.
- R10: Control write/read issue only when no register, unit, flag or block countdown is active.
- R11: An instruction whose destination register still has a pending result stalls until that result is ready.
- R12: `stall` and `issue` respond combinationally to the request and current state. `issue` = `req_valid` and not `stall`, and the state updates on the clock edge of an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An instruction is offered this cycle |
| req_class | input | 4 | Operation class code (R2) |
| req_dbl | input | 1 | Double precision |
| req_dst | input | 5 | Destination register field / block-load base |
| req_src_a | input | 5 | Source A field / block-store base |
| req_src_b | input | 5 | Source B field |
| req_count | input | 6 | Register count of a block transfer |
| stall | output | 1 | Offered instruction must wait |
| issue | output | 1 | Offered instruction starts this cycle |

## Verification
The bench offers dependent pairs and measures the exact issue cycle of the consumer. A scoreboard that drops the one-cycle forwarding credit issues one cycle late, and one that ignores the upper half of a double register issues early. Divide and double-multiply back-to-back pairs with an independent instruction between them expose a unit counter that blocks everything or blocks too briefly. Block loads with odd counts, a count of zero and a range wrapping past register 31 catch errors in the X rounding and in the range arithmetic. Control transfers placed behind a long divide, an add and a compare catch a drain test that overlooks a register, a unit or the flags. A store whose destination field names a register that is then read catches a design that creates a false dependency.

// File: rtl/fp_issue_sb.sv
module fp_issue_sb #(
  parameter int NREG     = 32,
  parameter int L_SHORT  = 4,
  parameter int L_ADD    = 8,
  parameter int L_MUL_S  = 8,
  parameter int L_MUL_D  = 9,
  parameter int L_DIV_S  = 19,
  parameter int L_DIV_D  = 33,
  parameter int T_MUL_S  = 1,
  parameter int T_MUL_D  = 2,
  parameter int T_DIV_S  = 15,
  parameter int T_DIV_D  = 29,
  parameter int XFER_ADD = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [3:0]               req_class,
  input  logic                     req_dbl,
  input  logic [$clog2(NREG)-1:0]  req_dst,
  input  logic [$clog2(NREG)-1:0]  req_src_a,
  input  logic [$clog2(NREG)-1:0]  req_src_b,
  input  logic [$clog2(NREG):0]    req_count,
  output logic                     stall,
  output logic                     issue
);

  localparam int RW   = $clog2(NREG);
  localparam int NW   = RW + 1;
  localparam int XMAX = NREG / 2 + 1 + XFER_ADD;
  localparam int LMAX = (L_DIV_D > XMAX) ? L_DIV_D : XMAX;
  localparam int CW   = $clog2(LMAX + 1);

  localparam logic [3:0] C_UNARY = 4'd0,  C_CMP   = 4'd1,  C_ADD   = 4'd2,
                         C_MUL   = 4'd3,  C_DIV   = 4'd4,  C_LOAD  = 4'd5,
                         C_STORE = 4'd6,  C_LDM   = 4'd7,  C_STM   = 4'd8,
                         C_TOFP  = 4'd9,  C_FROMFP= 4'd10, C_FLAGS = 4'd11,
                         C_CTLWR = 4'd12, C_CTLRD = 4'd13;

  function automatic logic [NREG-1:0] span(input logic [RW-1:0] base, input logic [NW-1:0] n);
    logic [NREG-1:0] m;
    logic [RW-1:0]   off;
    m = '0;
    for (int r = 0; r < NREG; r++) begin
      off  = RW'(r) - base;
      m[r] = ({1'b0, off} < n);
    end
    return m;
  endfunction

  logic [CW-1:0]   cnt [NREG];
  logic [NREG-1:0] pend;
  logic [CW-1:0]   div_cnt, mul_cnt, flag_cnt, blk_cnt;

  logic            is_xfer, wide, serial, hazard, drained;
  logic [NW-1:0]   n_eff, xfer_x, one_or_two;
  logic [RW-1:0]   dst_base, a_base, b_base;
  logic [NREG-1:0] src_mask, dst_mask;
  logic [CW-1:0]   dst_load, div_load, mul_load, blk_load;

  assign is_xfer    = (req_class == C_LDM) || (req_class == C_STM);
  assign wide       = req_dbl && !is_xfer;
  assign serial     = (req_class == C_CTLWR) || (req_class == C_CTLRD);
  assign n_eff      = (req_count == '0) ? NW'(1) : req_count;
  assign xfer_x     = (n_eff + NW'(1)) >> 1;
  assign one_or_two = wide ? NW'(2) : NW'(1);
  assign dst_base   = wide ? {req_dst[RW-2:0], 1'b0}   : req_dst;
  assign a_base     = wide ? {req_src_a[RW-2:0], 1'b0} : req_src_a;
  assign b_base     = wide ? {req_src_b[RW-2:0], 1'b0} : req_src_b;

  assign div_load = req_dbl ? CW'(T_DIV_D - 1) : CW'(T_DIV_S - 1);
  assign mul_load = req_dbl ? CW'(T_MUL_D - 1) : CW'(T_MUL_S - 1);
  assign blk_load = CW'(xfer_x) - CW'(1);

  always_comb begin
    src_mask = '0;
    case (req_class)
      C_UNARY, C_STORE, C_FROMFP:
        src_mask = span(a_base, one_or_two);
      C_CMP, C_ADD, C_MUL, C_DIV:
        src_mask = span(a_base, one_or_two) | span(b_base, one_or_two);
      C_STM:
        src_mask = span(req_src_a, n_eff);
      default: src_mask = '0;
    endcase
  end

  always_comb begin
    dst_mask = '0;
    dst_load = '0;
    case (req_class)
      C_UNARY, C_LOAD, C_TOFP: begin
        dst_mask = span(dst_base, one_or_two);
        dst_load = CW'(L_SHORT - 2);
      end
      C_ADD: begin
        dst_mask = span(dst_base, one_or_two);
        dst_load = CW'(L_ADD - 2);
      end
      C_MUL: begin
        dst_mask = span(dst_base, one_or_two);
        dst_load = req_dbl ? CW'(L_MUL_D - 2) : CW'(L_MUL_S - 2);
      end
      C_DIV: begin
        dst_mask = span(dst_base, one_or_two);
        dst_load = req_dbl ? CW'(L_DIV_D - 2) : CW'(L_DIV_S - 2);
      end
      C_LDM: begin
        dst_mask = span(req_dst, n_eff);
        dst_load = CW'(xfer_x) + CW'(XFER_ADD - 2);
      end
      default: begin
        dst_mask = '0;
        dst_load = '0;
      end
    endcase
  end

  assign drained = (pend == '0) && (div_cnt == '0) && (mul_cnt == '0) &&
                   (flag_cnt == '0) && (blk_cnt == '0);

  assign hazard = (|(src_mask & pend)) || (|(dst_mask & pend)) ||
                  (blk_cnt != '0) ||
                  ((req_class == C_DIV)   && (div_cnt  != '0)) ||
                  ((req_class == C_MUL)   && (mul_cnt  != '0)) ||
                  ((req_class == C_FLAGS) && (flag_cnt != '0)) ||
                  (serial && !drained);

  assign stall = req_valid && hazard;
  assign issue = req_valid && !hazard;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign pend[r] = (cnt[r] != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt[r] <= '0;
      else if (issue && dst_mask[r])  cnt[r] <= dst_load;
      else if (cnt[r] != '0)          cnt[r] <= cnt[r] - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               div_cnt <= '0;
    else if (issue && req_class == C_DIV)     div_cnt <= div_load;
    else if (div_cnt != '0)                   div_cnt <= div_cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mul_cnt <= '0;
    else if (issue && req_class == C_MUL)     mul_cnt <= mul_load;
    else if (mul_cnt != '0)                   mul_cnt <= mul_cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               flag_cnt <= '0;
    else if (issue && req_class == C_CMP)     flag_cnt <= CW'(L_SHORT - 2);
    else if (flag_cnt != '0)                  flag_cnt <= flag_cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               blk_cnt <= '0;
    else if (issue && is_xfer)                blk_cnt <= blk_load;
    else if (blk_cnt != '0)                   blk_cnt <= blk_cnt - CW'(1);
  end

  // R3
  add_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_class == C_ADD && !req_dbl) |=> (cnt[$past(req_dst)] == CW'(L_ADD - 2)));

  // R5
  mul_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_class == C_MUL && req_dbl) |=> !(issue && req_class == C_MUL));

  // R6
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_class == C_DIV) |=> !(issue && req_class == C_DIV));

  // R7
  xfer_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_xfer && req_count >= NW'(3)) |=> !issue);

  // R9
  flag_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_class == C_CMP) |=> !(issue && req_class == C_FLAGS));

  // R10
  serial_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && serial) |-> (pend == '0 && div_cnt == '0 && flag_cnt == '0));

endmodule

// File: tb/fp_issue_sb_test.sv
`timescale 1ns/1ps
module fp_issue_sb_test;
  localparam int LIMIT = 20000;

  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, req_dbl = 0;
  logic [3:0] req_class = 0;
  logic [4:0] req_dst = 0, req_src_a = 0, req_src_b = 0;
  logic [5:0] req_count = 0;
  logic       stall, issue;

  int checks = 0, errors = 0, cyc = 0, last_iss = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 0;

  fp_issue_sb uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_dbl(req_dbl), .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_count(req_count), .stall(stall), .issue(issue));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && issue) begin
      if (exp_q.size() == 0) chk(0, "R12 unexpected issue", cyc, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cyc == e, t, cyc, e);
      end
      last_iss = cyc;
    end
  end

  task automatic op(input int cls, input bit dbl, input int d, input int a, input int b,
                    input int n, input int gap, input string tag);
    @(posedge clk); #1;
    req_class = 4'(cls); req_dbl = dbl; req_dst = 5'(d);
    req_src_a = 5'(a); req_src_b = 5'(b); req_count = 6'(n); req_valid = 1;
    exp_q.push_back(gap <= 0 ? cyc : last_iss + gap);
    tag_q.push_back(tag);
    do begin
      @(negedge clk);
      if (!issue && cyc < LIMIT) chk(stall == 1'b1, "R12 stall while waiting", stall, 1);
    end while (!issue && cyc < LIMIT);
  endtask

  task automatic idle(input int k);
    @(posedge clk); #1;
    req_valid = 0;
    repeat (k) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(stall == 0 && issue == 0, "R1 reset outputs", {stall, issue}, 0);

    // R1 / R3 single-precision forwarding
    op(0, 0, 1, 2, 3, 0, 0, "R1 first request immediate");
    op(2, 0, 4, 1, 5, 0, 3, "R3 unary->add gap");
    op(0, 0, 6, 4, 0, 0, 7, "R3 add->unary gap");
    idle(40);

    // R5 / R4 multiply
    op(3, 0, 8, 20, 21, 0, 0, "R5 mul s");
    op(3, 0, 9, 22, 23, 0, 1, "R5 mul s back-to-back");
    op(3, 1, 5, 6, 7, 0, 1, "R5 mul d after mul s");
    op(3, 1, 8, 9, 10, 0, 2, "R5 mul d pair");
    op(2, 1, 11, 8, 9, 0, 8, "R4 mul d latency 9");
    idle(40);

    // R6 divide single
    op(4, 0, 10, 1, 2, 0, 0, "R6 div s");
    op(4, 0, 11, 3, 4, 0, 15, "R6 div s throughput");
    op(0, 0, 12, 13, 0, 0, 1, "R6 other class during div");
    op(0, 0, 14, 10, 0, 0, 2, "R3 div s latency 19");
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(stall == 0, "R1 no stall without request", stall, 0);
    idle(40);

    // R6 / R4 divide double and aliasing
    op(4, 1, 2, 3, 4, 0, 0, "R6 div d");
    op(4, 1, 5, 6, 7, 0, 29, "R6 div d throughput");
    op(0, 0, 20, 5, 0, 0, 3, "R4 upper half of double latency 33");
    idle(40);

    // R7 block load
    op(7, 0, 16, 0, 0, 5, 0, "R7 ldm N=5");
    op(0, 0, 1, 2, 0, 0, 3, "R7 block X=3");
    op(0, 0, 3, 20, 0, 0, 2, "R7 last loaded reg X+3");
    op(0, 0, 4, 21, 0, 0, 1, "R7 reg past range free");
    idle(40);
    op(7, 0, 30, 0, 0, 3, 0, "R7 ldm wrap");
    op(0, 0, 5, 0, 0, 0, 4, "R7 wrapped reg 0");
    idle(40);
    op(7, 0, 7, 0, 0, 0, 0, "R7 ldm N=0");
    op(0, 0, 9, 8, 0, 0, 1, "R7 N=0 covers one reg");
    op(0, 0, 10, 7, 0, 0, 2, "R7 N=0 latency 4");
    idle(40);

    // R8 no false results
    op(8, 0, 0, 4, 0, 4, 0, "R8 stm");
    op(0, 0, 1, 4, 0, 0, 2, "R8 stm makes no result");
    op(6, 0, 9, 3, 0, 0, 1, "R8 store");
    op(0, 0, 2, 9, 0, 0, 1, "R8 store dst ignored");
    op(10, 0, 13, 2, 0, 0, 3, "R3 fp->core waits source");
    op(0, 0, 6, 13, 0, 0, 1, "R8 fp->core dst ignored");
    idle(40);

    // R9 flags
    op(1, 0, 3, 1, 2, 0, 0, "R9 compare");
    op(0, 0, 4, 3, 0, 0, 1, "R9 compare writes no reg");
    op(11, 0, 0, 0, 0, 0, 2, "R9 flag transfer waits");
    op(9, 0, 7, 0, 0, 0, 1, "R2 core->fp");
    op(10, 0, 0, 7, 0, 0, 3, "R3 core->fp latency 4");
    idle(40);

    // R10 serializing
    op(2, 0, 1, 2, 3, 0, 0, "R10 add");
    op(12, 0, 0, 0, 0, 0, 7, "R10 ctl write drains add");
    op(4, 0, 2, 3, 4, 0, 1, "R10 div");
    op(13, 0, 0, 0, 0, 0, 18, "R10 ctl read drains div");
    op(1, 0, 0, 5, 6, 0, 1, "R10 compare");
    op(12, 0, 0, 0, 0, 0, 3, "R10 ctl waits flags");
    op(13, 0, 0, 0, 0, 0, 1, "R10 idle ctl immediate");
    idle(40);

    // R11 write-after-write
    op(4, 0, 7, 1, 2, 0, 0, "R11 div s7");
    op(2, 0, 7, 3, 4, 0, 18, "R11 add waits pending dst");
    idle(40);

    // R3 / R4 loads
    op(5, 0, 3, 0, 0, 0, 0, "R3 load");
    op(6, 0, 0, 3, 0, 0, 3, "R3 store waits load");
    op(5, 1, 6, 0, 0, 0, 1, "R4 double load");
    op(0, 0, 0, 13, 0, 0, 3, "R4 double load upper half");
    op(14, 0, 13, 13, 13, 0, 1, "R2 unused code");
    idle(10);

    chk(exp_q.size() == 0, "R12 pending expectations", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    wait (done || cyc >= LIMIT);
    if (!done) chk(0, "watchdog expired", cyc, LIMIT);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule